// File: doc/BRIEF.md
# Nested priority interrupt controller

This block gathers interrupt requests from four source classes (hardware faults such as a memory parity error, program exceptions such as overflow or divide by zero, the internal timer, and I/O controllers) and offers exactly one of them at a time to the processor. The processor accepts the offered request with an acknowledge pulse, and it closes the running handler with an end-of-service pulse. The controller records which source is being serviced and which services were interrupted.

A mode input selects the policy. In sequential mode a new interrupt is never offered while a service is running. Requests that arrive in the meantime wait, and they are offered in the order they arrived once the running service ends. In nesting mode a request of strictly higher priority than the running service is offered at once and preempts it. When the preempting service ends, the controller resumes the interrupted one. A four-entry in-service stack holds the chain of preempted levels. An arrival-order queue of source IDs tracks the pending requests in both modes, so a change of mode takes effect at any time without losing order.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset irq_o is 0, svc_vld_o is 0 and no request is pending.
- R2: Source IDs are 0 hardware fault, 1 program exception, 2 timer, 3 I/O. Bit n of req_i belongs to source n, and ID 0 has the highest priority and ID 3 the lowest. A request sampled high at a rising edge becomes pending, and it can be offered on irq_o from the following cycle.
- R3: In sequential mode (mode_i = 0), irq_o stays low whenever svc_vld_o is 1.
- R4: In sequential mode, pending sources are offered in the order they arrived, and arrivals in the same cycle are ordered by priority. Raising the request of a source that is already pending does not queue that source a second time.
- R5: In nesting mode (mode_i = 1), irq_o is high when a source is pending and either no service runs or the highest-priority pending source outranks svc_id_o. irq_id_o is then the highest-priority pending source.
- R6: An ack_i while irq_o is high grants irq_id_o. On the next cycle svc_vld_o is 1, svc_id_o equals the granted ID, and that source is no longer pending. An ack_i while irq_o is low changes nothing.
- R7: eoi_i ends the service shown on svc_id_o, and svc_id_o returns to the most recently preempted service, up to four levels deep. eoi_i with no service running changes nothing.
- R8: A change of mode_i affects irq_o in the same cycle, and pending requests are kept across the change.
- R9: A pending request stays pending until it is granted, even after its req_i line drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 sequential, 1 nesting |
| req_i | input | 4 | Request per source, bit n is source ID n |
| ack_i | input | 1 | Processor accepts the offered interrupt |
| eoi_i | input | 1 | Processor ends the running service |
| irq_o | output | 1 | Interrupt offered |
| irq_id_o | output | 2 | ID of the offered source |
| svc_vld_o | output | 1 | A service is running |
| svc_id_o | output | 2 | ID of the running service |

## Verification
The hardest states to reach are a full four-level nesting chain and a sequential queue whose order must survive a duplicate request and a mixed set of simultaneous arrivals. The bench holds each service open by withholding end-of-service. It then sweeps every arrival permutation of the four sources, every simultaneous-arrival mask and every ordered pair of running and arriving source in nesting mode. Afterwards it unwinds each case one end-of-service at a time and compares each offer against the order derived from the requirements.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NUM_SRC = 4;
  localparam int ID_W    = $clog2(NUM_SRC);

  typedef logic [ID_W-1:0] src_id_t;

  typedef enum logic {
    MODE_SEQ  = 1'b0,
    MODE_NEST = 1'b1
  } irq_mode_e;

  // lower ID = higher priority
  localparam src_id_t SRC_HWFAULT = 2'd0;
  localparam src_id_t SRC_PROG    = 2'd1;
  localparam src_id_t SRC_TIMER   = 2'd2;
  localparam src_id_t SRC_IO      = 2'd3;
endpackage

// File: rtl/irq_arrival_fifo.sv
module irq_arrival_fifo #(
  parameter int NUM_SRC = 4,
  parameter int DEPTH   = 4,
  parameter int ID_W    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] enq_i,
  input  logic               rm_i,
  input  logic [ID_W-1:0]    rm_id_i,
  output logic               head_vld_o,
  output logic [ID_W-1:0]    head_id_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ID_W-1:0] id_q [DEPTH];
  logic [ID_W-1:0] id_d [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;

  // compact out the granted ID, then append new arrivals in priority order
  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < DEPTH; i++) begin
      id_d[i]  = '0;
      vld_d[i] = 1'b0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && !(rm_i && id_q[i] == rm_id_i)) begin
        id_d[k[IDX_W-1:0]]  = id_q[i];
        vld_d[k[IDX_W-1:0]] = 1'b1;
        k++;
      end
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (enq_i[s] && k < DEPTH) begin
        id_d[k[IDX_W-1:0]]  = s[ID_W-1:0];
        vld_d[k[IDX_W-1:0]] = 1'b1;
        k++;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) id_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < DEPTH; i++) id_q[i] <= id_d[i];
    end
  end

  assign head_vld_o = vld_q[0];
  assign head_id_o  = id_q[0];
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [ID_W-1:0] push_id_i,
  input  logic            pop_i,
  output logic            top_vld_o,
  output logic [ID_W-1:0] top_id_o
);
  logic [ID_W-1:0] id_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic pop_eff;

  assign pop_eff = pop_i & vld_q[0];

  // entry 0 is the top; push shifts down, pop shifts up, both replace top
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ID_W-1:0] below_id, above_id;
    logic            below_vld;
    if (i == DEPTH - 1) begin : g_last
      assign below_id  = '0;
      assign below_vld = 1'b0;
    end else begin : g_mid
      assign below_id  = id_q[i+1];
      assign below_vld = vld_q[i+1];
    end
    if (i == 0) begin : g_top
      assign above_id = push_id_i;
    end else begin : g_lower
      assign above_id = id_q[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q[i]  <= '0;
        vld_q[i] <= 1'b0;
      end else if (push_i && pop_eff) begin
        if (i == 0) id_q[i] <= push_id_i;
      end else if (push_i) begin
        id_q[i]  <= above_id;
        vld_q[i] <= (i == 0) ? 1'b1 : vld_q[i-((i == 0) ? 0 : 1)];
      end else if (pop_eff) begin
        id_q[i]  <= below_id;
        vld_q[i] <= below_vld;
      end
    end
  end

  assign top_vld_o = vld_q[0];
  assign top_id_o  = id_q[0];
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int NUM_SRC = 4,
  parameter int ID_W    = 2
) (
  input  logic               mode_i,
  input  logic [NUM_SRC-1:0] pending_i,
  input  logic               head_vld_i,
  input  logic [ID_W-1:0]    head_id_i,
  input  logic               top_vld_i,
  input  logic [ID_W-1:0]    top_id_i,
  output logic               irq_o,
  output logic [ID_W-1:0]    irq_id_o
);
  logic [ID_W-1:0] best_id;

  always_comb begin
    best_id = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending_i[i]) best_id = i[ID_W-1:0];
    end
  end

  always_comb begin
    if (mode_i == irq_nest_pkg::MODE_NEST) begin
      irq_o    = (|pending_i) && (!top_vld_i || best_id < top_id_i);
      irq_id_o = best_id;
    end else begin
      irq_o    = head_vld_i && !top_vld_i;
      irq_id_o = head_id_i;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int QUEUE_DEPTH = NUM_SRC,
  parameter int STACK_DEPTH = NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               irq_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic               svc_vld_o,
  output logic [ID_W-1:0]    svc_id_o
);
  logic [NUM_SRC-1:0] pending_q, arrive, grant_mask;
  logic               ack_fire, head_vld;
  src_id_t            head_id;

  assign ack_fire   = ack_i & irq_o;
  assign grant_mask = ack_fire ? (NUM_SRC'(1) << irq_id_o) : '0;
  assign arrive     = req_i & ~pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= '0;
    else         pending_q <= (pending_q | req_i) & ~grant_mask;
  end

  irq_arrival_fifo #(
    .NUM_SRC(NUM_SRC), .DEPTH(QUEUE_DEPTH), .ID_W(ID_W)
  ) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enq_i     (arrive),
    .rm_i      (ack_fire),
    .rm_id_i   (irq_id_o),
    .head_vld_o(head_vld),
    .head_id_o (head_id)
  );

  irq_svc_stack #(
    .DEPTH(STACK_DEPTH), .ID_W(ID_W)
  ) u_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (ack_fire),
    .push_id_i(irq_id_o),
    .pop_i    (eoi_i),
    .top_vld_o(svc_vld_o),
    .top_id_o (svc_id_o)
  );

  irq_select #(
    .NUM_SRC(NUM_SRC), .ID_W(ID_W)
  ) u_sel (
    .mode_i    (mode_i),
    .pending_i (pending_q),
    .head_vld_i(head_vld),
    .head_id_i (head_id),
    .top_vld_i (svc_vld_o),
    .top_id_i  (svc_id_o),
    .irq_o     (irq_o),
    .irq_id_o  (irq_id_o)
  );
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk
  import irq_nest_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_i,
  input logic [NUM_SRC-1:0] req_i,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               irq_o,
  input logic [ID_W-1:0]    irq_id_o,
  input logic               svc_vld_o,
  input logic [ID_W-1:0]    svc_id_o
);
  assert_seq_no_grant_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SEQ && svc_vld_o) |-> !irq_o);

  assert_nest_outranks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NEST && irq_o && svc_vld_o) |-> (irq_id_o < svc_id_o));

  assert_ack_enters_service_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (svc_vld_o && svc_id_o == $past(irq_id_o)));

  assert_idle_eoi_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!svc_vld_o && !(ack_i && irq_o)) |=> !svc_vld_o);

  assert_service_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ack_i && irq_o) && !eoi_i) |=> ($stable(svc_vld_o) && $stable(svc_id_o)));

  // req_i is observed only through the pending path
  logic unused_req;
  assign unused_req = ^req_i;
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk u_chk (.*);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic [3:0] req_i = '0;
  logic       ack_i = 1'b0;
  logic       eoi_i = 1'b0;
  logic       irq_o, svc_vld_o;
  logic [1:0] irq_id_o, svc_id_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_nest_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .req_i(req_i),
    .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o), .irq_id_o(irq_id_o),
    .svc_vld_o(svc_vld_o), .svc_id_o(svc_id_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic pulse_req(input logic [3:0] m);
    req_i = m; step(); req_i = '0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic do_eoi();
    eoi_i = 1'b1; step(); eoi_i = 1'b0;
  endtask

  task automatic expect_irq(input string tag, input int id);
    chk({tag, " irq"}, int'(irq_o), 1);
    chk({tag, " id"}, int'(irq_id_o), id);
  endtask

  task automatic expect_svc(input string tag, input int id);
    chk({tag, " svc_vld"}, int'(svc_vld_o), 1);
    chk({tag, " svc_id"}, int'(svc_id_o), id);
  endtask

  task automatic expect_idle(input string tag);
    chk({tag, " idle irq"}, int'(irq_o), 0);
    chk({tag, " idle svc"}, int'(svc_vld_o), 0);
  endtask

  initial begin
    int p[4];
    #5;
    // R1 reset state
    expect_idle("R1 in reset");
    step(); step();
    rst_ni = 1'b1;
    step();
    expect_idle("R1 after reset");

    // R9 pending held after request drops; R2 one-cycle latency
    pulse_req(4'b0100);
    expect_irq("R2 latency", 2);
    repeat (5) step();
    expect_irq("R9 held", 2);
    do_ack();
    expect_svc("R6 grant", 2);
    do_eoi();
    expect_idle("R7 end");

    // R6/R7 ignored strobes
    do_ack();
    expect_idle("R6 ack ignored");
    do_eoi();
    expect_idle("R7 eoi ignored");

    // R3/R4 sequential mode: all arrival permutations
    mode_i = 1'b0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
            p[0] = a; p[1] = b; p[2] = c; p[3] = d;
            pulse_req(4'(1 << p[0]));
            expect_irq("R4 first", p[0]);
            do_ack();
            for (int k = 1; k < 4; k++) begin
              pulse_req(4'(1 << p[k]));
              chk("R3 held while busy", int'(irq_o), 0);
            end
            for (int k = 1; k < 4; k++) begin
              do_eoi();
              expect_irq("R4 arrival order", p[k]);
              do_ack();
              expect_svc("R6 seq grant", p[k]);
            end
            do_eoi();
            expect_idle("R4 perm done");
          end

    // R4 simultaneous arrivals ordered by priority
    for (int m = 1; m < 16; m++) begin
      pulse_req(4'b1000);
      do_ack();
      pulse_req(4'(m));
      chk("R3 busy mask", int'(irq_o), 0);
      for (int id = 0; id < 4; id++) begin
        if (m[id]) begin
          do_eoi();
          expect_irq("R4 same-cycle order", id);
          do_ack();
        end
      end
      do_eoi();
      expect_idle("R4 mask done");
    end

    // R4 duplicate request not queued twice
    pulse_req(4'b0001);
    do_ack();
    pulse_req(4'b0100);
    pulse_req(4'b0010);
    pulse_req(4'b0100);
    do_eoi();
    expect_irq("R4 dup first", 2);
    do_ack();
    do_eoi();
    expect_irq("R4 dup second", 1);
    do_ack();
    do_eoi();
    expect_idle("R4 dup no repeat");

    // R5/R7 nesting mode: every running/arriving pair
    mode_i = 1'b1;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        pulse_req(4'(1 << a));
        do_ack();
        expect_svc("R6 nest base", a);
        pulse_req(4'(1 << b));
        if (b < a) begin
          expect_irq("R5 preempt", b);
          do_ack();
          expect_svc("R5 preempted", b);
          do_eoi();
          expect_svc("R7 resume", a);
          chk("R5 no irq on resume", int'(irq_o), 0);
          do_eoi();
        end else begin
          chk("R5 no preempt", int'(irq_o), 0);
          do_eoi();
          expect_irq("R5 after end", b);
          do_ack();
          do_eoi();
        end
        expect_idle("R5 pair done");
      end

    // R2 simultaneous in nesting mode picks highest
    pulse_req(4'b1111);
    expect_irq("R2 highest", 0);
    do_ack();
    do_eoi();
    expect_irq("R2 next", 1);
    do_ack(); do_eoi();
    do_ack(); do_eoi();
    do_ack(); do_eoi();
    expect_idle("R2 drained");

    // R7 four-level chain
    for (int id = 3; id >= 0; id--) begin
      pulse_req(4'(1 << id));
      expect_irq("R5 chain", id);
      do_ack();
    end
    for (int id = 0; id < 4; id++) begin
      expect_svc("R7 unwind", id);
      do_eoi();
    end
    expect_idle("R7 chain done");

    // R8 mode switch with a pending higher request
    mode_i = 1'b0;
    pulse_req(4'b1000);
    do_ack();
    pulse_req(4'b0001);
    chk("R8 seq blocks", int'(irq_o), 0);
    mode_i = 1'b1;
    #1;
    expect_irq("R8 switch to nest", 0);
    do_ack();
    expect_svc("R8 nested", 0);
    do_eoi();
    expect_svc("R8 resume", 3);
    do_eoi();
    expect_idle("R8 done");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule